// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block carries out logical shifts, plain rotates and rotates through the extend bit on byte, word or long operands. It also produces the five condition flags that such operations define. Operands live left-aligned in a 32-bit word: a byte sits in bits 31:24, a word in bits 31:16 and a long fills the whole word. Any bits below the operand are ignored on input and are zero on output.

A request is presented for one clock with `in_valid` high. It carries the operand, a 6-bit count, the size, the operation class, the direction and the current extend flag. The whole operation is done in a single combinational pass: one lane of shift logic per operand size, with the active lane selected by size. The next cycle shows the aligned result, the flags and the cycle cost of the shift, together with a one-cycle `done` pulse. The outputs then hold until the next request.

Top module: `shrot_unit`

## Requirements
- R1: `size` selects the operand width: 00 is a byte in bits 31:24, 01 is a word in bits 31:16, and 10 or 11 is a long in bits 31:0. Operand bits below the selected field do not affect any output, and the result is zero in those bits.
- R2: When `op` is 00 (or 11, which behaves the same), the operand is shifted logically: right when `dir_left` is 0 and left when it is 1. Vacated bits are filled with zero, and a count of operand width or more gives a zero result.
- R3: For a logical shift, C and X both equal the last bit shifted out of the operand when the count is between 1 and the operand width. Both are 0 when the count is 0 or larger than the width. A zero count leaves the operand unchanged.
- R4: When `op` is 01, the operand is rotated by the count modulo its width. X equals `x_in`. C is 0 for a zero count. For a nonzero count, C is the result's top operand bit (bit 31) for a right rotate and the result's lowest operand bit for a left rotate.
- R5: When `op` is 10, the operand and `x_in` form a ring one bit wider than the operand, with X just above the operand's top bit. The ring is rotated by the count modulo the operand width. X and C both take the ring's extend position afterwards. When the reduced count is 0, the result is unchanged and C equals X equals `x_in`.
- R6: N equals result bit 31, and Z is 1 exactly when the result is zero. V is always 0.
- R7: `cycles` equals twice the count input.
- R8: A request with `in_valid` high at a rising edge updates the result, flags and `cycles` at that edge and raises `done` for exactly that following cycle. Without a request, all outputs hold their values.
- R9: During synchronous active-low reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Left-aligned operand |
| count | input | 6 | Shift or rotate count, 0 to 63 |
| size | input | 2 | 00 byte, 01 word, 10/11 long |
| op | input | 2 | 00/11 logical shift, 01 rotate, 10 rotate through extend |
| dir_left | input | 1 | 1 shifts left, 0 shifts right |
| x_in | input | 1 | Incoming extend flag |
| done | output | 1 | One-cycle pulse marking fresh outputs |
| result | output | 32 | Left-aligned result |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag |
| cycles | output | 7 | Cycle cost of the shift portion |

## Verification
Several rules are checked by the assertions on every cycle: the timing of `done`, output holding between requests, zero low bits for byte and word sizes, N, Z and V against the result, `cycles` against the count, clearing of C and X on a zero-count logical shift, and X passing through unchanged on a plain rotate. Other behaviour can only be shown by the bench's scenarios, which compare against a bit-by-bit stepping model. This covers the actual shifted and rotated values, which bit ends up in C, the counts that exceed the operand width, the count reduction modulo the width, and the insertion of the old extend bit in the extend rotate.

// File: rtl/shrot_pkg.sv
// Package: shared encodings for the shift/rotate unit.
// Assumes the operation and size codes fixed in the brief.
package shrot_pkg;
    typedef enum logic [1:0] {
        OP_LSH = 2'b00,
        OP_ROT = 2'b01,
        OP_ROX = 2'b10,
        OP_ALT = 2'b11
    } shrot_op_e;

    localparam int NUM_LANES = 3;

    // Maps the size code to a lane index: 0 byte, 1 word, 2 long.
    function automatic int unsigned lane_of(input logic [1:0] sz);
        case (sz)
            2'b00:   return 0;
            2'b01:   return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/shrot_lane.sv
// Module: shrot_lane
// Computes the shifted or rotated value of a right-aligned W-bit operand
// plus the resulting X and C bits. It is purely combinational.
// Assumes that W is a power of two and that $clog2(W) <= CNT_W.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     val,
    input  logic [CNT_W-1:0] cnt,
    input  shrot_op_e        op,
    input  logic             dir_left,
    input  logic             x_in,
    output logic [W-1:0]     res,
    output logic             x_out,
    output logic             c_out
);
    localparam int RW = $clog2(W);
    localparam logic [RW:0]   WV = W[RW:0];
    localparam logic [RW+1:0] WP = RW'(0) + (RW+2)'(W + 1);

    logic [RW-1:0] rot_amt;
    logic [RW:0]   rot_back;
    logic [RW+1:0] ring_back;
    logic [W-1:0]  sh_val, rot_val;
    logic [W:0]    pad_r, pad_l, ring, ring_val;
    logic          last_out;

    // Reduce the rotate count modulo the operand width and form its complements.
    always_comb begin
        rot_amt   = cnt[RW-1:0];
        rot_back  = WV - {1'b0, rot_amt};
        ring_back = WP - {2'b00, rot_amt};
    end

    // Logical shift and capture of the last bit that left the operand.
    always_comb begin
        sh_val   = dir_left ? (val << cnt) : (val >> cnt);
        pad_r    = {val, 1'b0} >> cnt;
        pad_l    = {1'b0, val} << cnt;
        last_out = dir_left ? pad_l[W] : pad_r[0];
    end

    // Plain rotate, and rotate of the ring formed by X above the operand.
    always_comb begin
        ring = {x_in, val};
        if (dir_left) begin
            rot_val  = (val << rot_amt) | (val >> rot_back);
            ring_val = (ring << rot_amt) | (ring >> ring_back);
        end else begin
            rot_val  = (val >> rot_amt) | (val << rot_back);
            ring_val = (ring >> rot_amt) | (ring << ring_back);
        end
    end

    // Select the result and the X/C update rule for the operation class.
    always_comb begin
        case (op)
            OP_ROT: begin
                res   = rot_val;
                x_out = x_in;
                c_out = (cnt != '0) && (dir_left ? rot_val[0] : rot_val[W-1]);
            end
            OP_ROX: begin
                res   = ring_val[W-1:0];
                x_out = ring_val[W];
                c_out = ring_val[W];
            end
            default: begin
                res   = sh_val;
                x_out = last_out;
                c_out = last_out;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
// Module: shrot_flags
// Derives N, Z and V from the aligned result and the cycle cost from the count.
// Assumes that the result is already masked to the operand size.
module shrot_flags #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] res,
    input  logic [CNT_W-1:0]  cnt,
    output logic              n_flag,
    output logic              z_flag,
    output logic              v_flag,
    output logic [CNT_W:0]    cost
);
    // Sign, zero and overflow flags, plus two cycles per count position.
    always_comb begin
        n_flag = res[DATA_W-1];
        z_flag = (res == '0);
        v_flag = 1'b0;
        cost   = {cnt, 1'b0};
    end
endmodule

// File: rtl/shrot_unit.sv
// Module: shrot_unit (top)
// Shift/rotate unit for left-aligned byte, word and long operands. It holds
// one combinational lane per size, picks the lane by size, and registers the
// result, the flags and the cycle cost on in_valid.
// Assumes DATA_W is divisible by 4 and that DATA_W/4 is a power of two.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        size,
    input  logic [1:0]        op,
    input  logic              dir_left,
    input  logic              x_in,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              flag_x,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic [CNT_W:0]    cycles
);
    shrot_op_e         op_e;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_x   [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic [DATA_W-1:0] sel_res;
    logic              sel_x, sel_c, nxt_n, nxt_z, nxt_v;
    logic [CNT_W:0]    nxt_cost;

    assign op_e = shrot_op_e'(op);

    // One lane per operand size; the lane result is placed back at the top.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
        logic [LW-1:0] lres;
        shrot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .val      (operand[DATA_W-1 -: LW]),
            .cnt      (count),
            .op       (op_e),
            .dir_left (dir_left),
            .x_in     (x_in),
            .res      (lres),
            .x_out    (lane_x[g]),
            .c_out    (lane_c[g])
        );
        if (LW == DATA_W) begin : g_full
            assign lane_res[g] = lres;
        end else begin : g_part
            assign lane_res[g] = {lres, {(DATA_W-LW){1'b0}}};
        end
    end

    // Pick the lane that matches the requested size.
    always_comb begin
        sel_res = lane_res[lane_of(size)];
        sel_x   = lane_x[lane_of(size)];
        sel_c   = lane_c[lane_of(size)];
    end

    shrot_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_flags (
        .res    (sel_res),
        .cnt    (count),
        .n_flag (nxt_n),
        .z_flag (nxt_z),
        .v_flag (nxt_v),
        .cost   (nxt_cost)
    );

    // Output registers: load on a request, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            flag_x <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            cycles <= '0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                result <= sel_res;
                flag_x <= sel_x;
                flag_n <= nxt_n;
                flag_z <= nxt_z;
                flag_v <= nxt_v;
                flag_c <= sel_c;
                cycles <= nxt_cost;
            end
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
// Module: shrot_unit_chk
// Concurrent checks on the shift/rotate unit's ports, bound into every instance.
module shrot_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] operand,
    input logic [CNT_W-1:0]  count,
    input logic [1:0]        size,
    input logic [1:0]        op,
    input logic              dir_left,
    input logic              x_in,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              flag_x,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c,
    input logic [CNT_W:0]    cycles
);
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cycles) && $stable(flag_c) && $stable(flag_x)));
    p_byte_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'b00) |=> (result[DATA_W-9:0] == '0));
    p_word_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'b01) |=> (result[DATA_W/2-1:0] == '0));
    p_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_n == result[DATA_W-1] && flag_z == (result == '0)));
    p_v_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v);
    p_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cycles == {$past(count), 1'b0}));
    p_zero_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[0] == op[1] && count == '0) |=> (!flag_c && !flag_x && result == $past(result_aligned(operand, size))));
    p_rot_keeps_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01) |=> (flag_x == $past(x_in)));

    // Masks the operand to its size field, as an unshifted result would be.
    function automatic logic [DATA_W-1:0] result_aligned(input logic [DATA_W-1:0] v,
                                                         input logic [1:0] sz);
        case (sz)
            2'b00:   return {v[DATA_W-1 -: 8], {(DATA_W-8){1'b0}}};
            2'b01:   return {v[DATA_W-1 -: DATA_W/2], {(DATA_W/2){1'b0}}};
            default: return v;
        endcase
    endfunction
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
// Bench for shrot_unit: directed corner cases followed by seeded random
// requests, each compared against a bit-stepping reference model.
module shrot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [5:0]  count = '0;
    logic [1:0]  size = '0;
    logic [1:0]  op = '0;
    logic        dir_left = 1'b0;
    logic        x_in = 1'b0;
    logic        done;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;
    logic [6:0]  cycles;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .count(count), .size(size), .op(op), .dir_left(dir_left), .x_in(x_in),
        .done(done), .result(result), .flag_x(flag_x), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .cycles(cycles)
    );

    // Counts one check and reports it on mismatch.
    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model: steps the operand one bit position at a time.
    function automatic void model(input logic [31:0] opnd, input int n,
                                  input logic [1:0] sz, input logic [1:0] o,
                                  input logic left, input logic xi,
                                  output logic [31:0] r, output logic xo,
                                  output logic co);
        int w;
        logic [63:0] v, mask;
        logic last, xx, nb;
        w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        v    = (64'(opnd) >> (32 - w)) & mask;
        if (o == 2'b01) begin
            for (int i = 0; i < n % w; i++)
                if (left) v = ((v << 1) & mask) | 64'(v[w-1]);
                else      v = (v >> 1) | (64'(v[0]) << (w - 1));
            xo = xi;
            co = (n == 0) ? 1'b0 : (left ? v[0] : v[w-1]);
        end else if (o == 2'b10) begin
            xx = xi;
            for (int i = 0; i < n % w; i++) begin
                if (left) begin nb = v[w-1]; v = ((v << 1) & mask) | 64'(xx); end
                else      begin nb = v[0];   v = (v >> 1) | (64'(xx) << (w - 1)); end
                xx = nb;
            end
            xo = xx;
            co = xx;
        end else begin
            last = 1'b0;
            for (int i = 0; i < n; i++)
                if (left) begin last = v[w-1]; v = (v << 1) & mask; end
                else      begin last = v[0];   v = v >> 1; end
            xo = last;
            co = last;
        end
        r = 32'(v << (32 - w));
    endfunction

    // Issues one request, then checks the outputs and their holding.
    task automatic run_case(input logic [31:0] opnd, input logic [5:0] n,
                            input logic [1:0] sz, input logic [1:0] o,
                            input logic left, input logic xi, input string tag);
        logic [31:0] er;
        logic ex, ec;
        model(opnd, int'(n), sz, o, left, xi, er, ex, ec);
        @(negedge clk);
        operand = opnd; count = n; size = sz; op = o; dir_left = left; x_in = xi;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        operand = ~opnd; count = ~n; x_in = ~xi;
        check("R8", "done", 32'(done), 32'd1);
        check(tag, "result", result, er);
        check(tag, "flag_c", 32'(flag_c), 32'(ec));
        check(tag, "flag_x", 32'(flag_x), 32'(ex));
        check("R6", "flag_n", 32'(flag_n), 32'(er[31]));
        check("R6", "flag_z", 32'(flag_z), 32'(er == 32'd0));
        check("R6", "flag_v", 32'(flag_v), 32'd0);
        check("R7", "cycles", 32'(cycles), 32'(n) * 2);
        @(negedge clk);
        check("R8", "done low", 32'(done), 32'd0);
        check("R8", "hold", result, er);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9", "reset result", result, 32'd0);
        check("R9", "reset done", 32'(done), 32'd0);
        check("R9", "reset flags", 32'({flag_x, flag_n, flag_z, flag_v, flag_c}), 32'd0);
        check("R9", "reset cycles", 32'(cycles), 32'd0);
        rst_n = 1'b1;

        // R2/R3: byte right shift by one, low bit goes to C and X
        run_case(32'h81AB_CDEF, 6'd1, 2'b00, 2'b00, 1'b0, 1'b0, "R3");
        // R3: word left shift by exactly the width, C takes operand bit 0
        run_case(32'h0001_5555, 6'd16, 2'b01, 2'b00, 1'b1, 1'b0, "R3");
        // R3: count just past the width, zero result and cleared C/X
        run_case(32'hFFFF_0000, 6'd17, 2'b01, 2'b00, 1'b1, 1'b1, "R3");
        // R3: zero count clears X even when x_in is set
        run_case(32'h8000_0001, 6'd0, 2'b10, 2'b00, 1'b0, 1'b1, "R3");
        // R2: long right shift by the largest count
        run_case(32'hFFFF_FFFF, 6'd63, 2'b10, 2'b00, 1'b0, 1'b0, "R2");
        // R2: code 11 behaves as a logical shift, size 11 as long
        run_case(32'hC000_0003, 6'd2, 2'b11, 2'b11, 1'b0, 1'b0, "R2");
        // R1: bits below a byte operand are ignored
        run_case(32'h4012_3456, 6'd1, 2'b00, 2'b00, 1'b1, 1'b0, "R1");
        // R4: byte rotate by its width, C from the result's top bit, X kept
        run_case(32'h8100_0000, 6'd8, 2'b00, 2'b01, 1'b0, 1'b1, "R4");
        // R4: word rotate left with a count reduced modulo 16
        run_case(32'h8001_0000, 6'd17, 2'b01, 2'b01, 1'b1, 1'b0, "R4");
        // R4: zero-count rotate clears C
        run_case(32'hFFFF_FFFF, 6'd0, 2'b10, 2'b01, 1'b1, 1'b0, "R4");
        // R5: rotate through extend inserts the old X at the top
        run_case(32'h0000_0000, 6'd1, 2'b00, 2'b10, 1'b0, 1'b1, "R5");
        // R5: left rotate through extend, operand top bit lands in X
        run_case(32'h8000_0000, 6'd1, 2'b10, 2'b10, 1'b1, 1'b0, "R5");
        // R5: reduced count of zero gives C equal to x_in
        run_case(32'h1234_0000, 6'd32, 2'b01, 2'b10, 1'b0, 1'b1, "R5");

        for (int k = 0; k < 400; k++) begin
            logic [1:0] o;
            string t;
            o = 2'($urandom);
            t = (o == 2'b01) ? "R4" : (o == 2'b10) ? "R5" : "R2";
            run_case($urandom, 6'($urandom), 2'($urandom), o, 1'($urandom),
                     1'($urandom), t);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule